// File: doc/BRIEF.md
# Half-Duplex Serial ADC Conversion Controller

This block is a bus master that runs one conversion on a serial ADC whose data input and data output share a single wire. On a start strobe it drops chip select and generates a serial clock from the system clock. It sends a start bit and a three-bit configuration word. It then stops driving the shared wire at a fixed point between the fourth rising and fourth falling serial clock edge. After that it shifts in the converter's reply.

The reply opens with one null bit, which is thrown away, and continues with twelve result bits, most significant bit first. When chip select rises again, the block presents the result as a 16-bit word together with a one-cycle done pulse. A system-level wrapper drives the data pin from `sd_o` when `sd_oe_o` is high and feeds the pin value back on `sd_i`.

Top module: `adc_halfduplex_ctrl`

## Requirements
- R1: During and after synchronous reset, `cs_n_o`=1, `sclk_o`=0, `sd_oe_o`=0, `done_o`=0 and `result_o`=0.
- R2: A `start_i` seen at a clock edge while idle drives `cs_n_o` low at that edge (E0). One serial half-period is H = `div_i`+2 system cycles. `sclk_o` first rises at E0+H and toggles every H cycles after that. `sclk_o` stays low whenever `cs_n_o` is high.
- R3: While `sd_oe_o` is high, `sd_o` carries four command bits in this order: 1, `cfg_i[2]` (single/differential), `cfg_i[1]` (odd/sign), `cfg_i[0]` (MSB first). Each bit is set up while `sclk_o` is low and is held across the following rising edge.
- R4: `sd_oe_o` rises together with the fall of `cs_n_o`. It falls one system cycle after the fourth rising `sclk_o` edge, at E0+7H+1, which is while `sclk_o` is high. It is low whenever `cs_n_o` is high.
- R5: After turnaround, `sd_i` is sampled 13 times, each in the last system cycle of a low serial phase. The first sample is a null bit and is discarded.
- R6: The twelve kept samples B11..B0, in arrival order, are packed as `result_o` = {B11..B0, 4'b0000}.
- R7: `cs_n_o` rises at E0+34H. `done_o` is high for exactly that one cycle. At that cycle `result_o` carries the new word, and it holds that value until the next done pulse.
- R8: A `start_i` that arrives while `cs_n_o` is low is ignored. No second transaction follows the current one.
- R9: `cfg_i` and `div_i` are captured at the accepted start. Changing them during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| cfg_i | input | 3 | {single/diff, odd/sign, MSB-first} |
| div_i | input | DIV_W | Serial half-period is div_i+2 system cycles |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Data driven onto the shared wire |
| sd_oe_o | output | 1 | Tri-state enable for the shared wire |
| sd_i | input | 1 | Value read back from the shared wire |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | OUT_W | Packed conversion result |

## Verification
All timing is counted from the clock edge that accepts the strobe (E0), with H = `div_i`+2:
- the first rising serial edge is due H cycles later;
- the enable release is due at E0+7H+1;
- chip select and done are due at E0+34H;
- the done pulse must be gone one cycle after that.

The bench drives inputs at falling system clock edges. It samples every output at the falling edge that follows each register update and compares against the cycle index it computes for each event. A behavioural slave latches the command on rising serial edges and shifts its reply out on falling serial edges. Its null bit is set to the opposite of B11, so a design that kept the null bit would produce a wrong word.

// File: rtl/adc_hd_pkg.sv
package adc_hd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_hd_halfclk.sv
// Half-period timer: pulses tick on the last system cycle of each serial half-period.
module adc_hd_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] reload_d;

  // div+1 loaded -> div+2 cycles per half-period (minimum two)
  assign reload_d = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (restart) begin
      cnt_q    <= reload_d;
      reload_q <= reload_d;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - {{DIV_W{1'b0}}, 1'b1};
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/adc_hd_seq.sv
// Transaction sequencer: chip select, serial clock, command bits, turnaround.
module adc_hd_seq
  import adc_hd_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CMD_W-2:0] cfg_i,
  input  logic             tick,
  output logic             restart,
  output logic             run,
  output logic             sample,
  output logic             finish,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o
);
  localparam int CFG_W = CMD_W - 1;
  localparam int TOTAL = CMD_W + RES_W + 1;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] TURN_IDX = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [CFG_W-1:0] cfg_q;

  assign run     = (phase_q != PH_IDLE);
  assign restart = (phase_q == PH_IDLE) && start_i;
  assign sample  = (phase_q == PH_LOW) && tick && (idx_q > TURN_IDX);
  assign finish  = (phase_q == PH_HIGH) && tick && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cfg_q   <= '0;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      sd_o    <= 1'b0;
      sd_oe_o <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_LOW;
            idx_q   <= '0;
            cfg_q   <= cfg_i;
            cs_n_o  <= 1'b0;
            sclk_o  <= 1'b0;
            sd_o    <= 1'b1;      // start bit
            sd_oe_o <= 1'b1;
          end
        end
        PH_LOW: begin
          if (tick) begin
            sclk_o  <= 1'b1;
            phase_q <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          // release the wire in the first cycle of the last command high phase
          if (idx_q == TURN_IDX) sd_oe_o <= 1'b0;
          if (tick) begin
            sclk_o <= 1'b0;
            if (idx_q == LAST_IDX) begin
              phase_q <= PH_IDLE;
              cs_n_o  <= 1'b1;
              sd_o    <= 1'b0;
              sd_oe_o <= 1'b0;
            end else begin
              phase_q <= PH_LOW;
              idx_q   <= idx_q + IDX_ONE;
              if (idx_q < TURN_IDX) begin
                sd_o  <= cfg_q[CFG_W-1];
                cfg_q <= {cfg_q[CFG_W-2:0], 1'b0};
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_hd_capture.sv
// Reply capture: drops the null bit, shifts result bits, packs on finish.
module adc_hd_capture #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             sd_i,
  input  logic             finish,
  output logic [OUT_W-1:0] result_o,
  output logic             done_o
);
  localparam int PAD_W = OUT_W - RES_W;

  logic [RES_W-1:0] sh_q;
  logic             null_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      null_q   <= 1'b1;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish;
      if (clear) begin
        sh_q   <= '0;
        null_q <= 1'b1;
      end else if (sample) begin
        if (null_q) null_q <= 1'b0;
        else        sh_q   <= {sh_q[RES_W-2:0], sd_i};
      end
      if (finish) result_o <= {sh_q, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/adc_halfduplex_ctrl.sv
module adc_halfduplex_ctrl #(
  parameter int DIV_W = 8,
  parameter int CMD_W = 4,
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CMD_W-2:0] cfg_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i,
  output logic             done_o,
  output logic [OUT_W-1:0] result_o
);
  logic restart, run, tick, sample, finish;

  adc_hd_halfclk #(.DIV_W(DIV_W)) u_halfclk (
    .clk(clk), .rst(rst), .restart(restart), .run(run), .div_i(div_i), .tick(tick)
  );

  adc_hd_seq #(.CMD_W(CMD_W), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i), .tick(tick),
    .restart(restart), .run(run), .sample(sample), .finish(finish),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  adc_hd_capture #(.RES_W(RES_W), .OUT_W(OUT_W)) u_capture (
    .clk(clk), .rst(rst), .clear(restart), .sample(sample), .sd_i(sd_i),
    .finish(finish), .result_o(result_o), .done_o(done_o)
  );
endmodule

// File: rtl/adc_hd_checks.sv
module adc_hd_checks #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             sd_o,
  input logic             sd_oe_o,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o
);
  localparam int PAD_W = OUT_W - RES_W;

  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sd_oe_o);

  assert_release_in_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_oe_o) |-> (sclk_o && !cs_n_o));

  assert_setup_while_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sd_o) && !cs_n_o) |-> !sclk_o);

  assert_done_at_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(cs_n_o));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  assert_pack_zero_nibble_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o[PAD_W-1:0] == '0));
endmodule

bind adc_halfduplex_ctrl adc_hd_checks #(.RES_W(RES_W), .OUT_W(OUT_W)) u_checks (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sd_o(sd_o),
  .sd_oe_o(sd_oe_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/test_adc_halfduplex_ctrl.sv
module test_adc_halfduplex_ctrl;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [2:0]       cfg_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic             cs_n_o, sclk_o, sd_o, sd_oe_o, done_o;
  logic [15:0]      result_o;
  logic             sd_line;

  int vectors = 0;
  int errors  = 0;
  bit reported = 0;

  // behavioural converter
  logic [11:0] slv_word;
  logic [3:0]  slv_cmd;
  int          slv_rises, slv_falls;
  logic        slv_en, slv_bit;

  always #10 clk = ~clk;  // 50 MHz

  assign sd_line = sd_oe_o ? sd_o : (slv_en ? slv_bit : 1'b1);

  adc_halfduplex_ctrl #(.DIV_W(DIV_W)) i_adc_halfduplex_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i), .div_i(div_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
    .sd_i(sd_line), .done_o(done_o), .result_o(result_o)
  );

  initial begin
    slv_en = 1'b0; slv_bit = 1'b0; slv_rises = 0; slv_falls = 0; slv_cmd = '0;
  end

  always @(negedge cs_n_o) begin
    slv_rises = 0; slv_falls = 0; slv_en = 1'b0; slv_cmd = '0;
  end

  always @(posedge cs_n_o) slv_en = 1'b0;

  always @(posedge sclk_o) begin
    if (!cs_n_o && slv_rises < 4) slv_cmd = {slv_cmd[2:0], sd_line};
    slv_rises++;
  end

  always @(negedge sclk_o) begin
    if (!cs_n_o) begin
      slv_falls++;
      if (slv_falls == 4) begin
        slv_en  = 1'b1;
        slv_bit = ~slv_word[11];          // null bit, must be dropped
      end else if (slv_falls >= 5 && slv_falls <= 16) begin
        slv_bit = slv_word[16 - slv_falls];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  endtask

  task automatic run_one(input int div, input logic [2:0] cfg, input logic [11:0] word);
    int h, k, oe_k, rise_k, done_k;
    logic [15:0] got;
    h = div + 2;
    slv_word = word;
    @(negedge clk);
    div_i = DIV_W'(div); cfg_i = cfg; start_i = 1'b1;
    @(posedge clk);                        // E0
    @(negedge clk);
    start_i = 1'b0;
    cfg_i = ~cfg; div_i = DIV_W'(div + 3); // R9: must not disturb this run
    check(!cs_n_o && !sclk_o && sd_oe_o && sd_o, "R2", "start state",
          {cs_n_o, sclk_o, sd_oe_o, sd_o}, 4'b0011);
    oe_k = -1; rise_k = -1; done_k = -1; got = '0;
    for (k = 0; k < 4000; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 3) start_i = 1'b1;          // R8: start while busy
      if (k == 4) start_i = 1'b0;
      if (sd_oe_o && slv_en) check(0, "R4", "bus contention", 1, 0);
      if (oe_k < 0 && !sd_oe_o) oe_k = k;
      if (rise_k < 0 && sclk_o) rise_k = k;
      if (done_o) begin
        done_k = k; got = result_o;
        break;
      end
    end
    check(rise_k == h, "R2", "first rising edge cycle", rise_k, h);
    check(oe_k == 7*h + 1, "R4", "release cycle", oe_k, 7*h + 1);
    check(done_k == 34*h, "R7", "done cycle", done_k, 34*h);
    check(cs_n_o && !sclk_o && !sd_oe_o, "R7", "deselect with done",
          {cs_n_o, sclk_o, sd_oe_o}, 3'b100);
    check(slv_cmd == {1'b1, cfg}, "R3", "command bits", slv_cmd, {1'b1, cfg});
    check(slv_cmd == {1'b1, cfg}, "R9", "config captured at start", slv_cmd, {1'b1, cfg});
    check(got == {word, 4'b0000}, "R6", "packed result", got, {word, 4'b0000});
    check(got == {word, 4'b0000}, "R5", "null bit dropped", got, {word, 4'b0000});
    @(negedge clk);
    check(!done_o, "R7", "done one cycle", done_o, 0);
    check(result_o == {word, 4'b0000}, "R7", "result held", result_o, {word, 4'b0000});
    @(negedge clk);
    @(negedge clk);
    check(cs_n_o, "R8", "no queued transaction", cs_n_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    slv_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cs_n_o && !sclk_o && !sd_oe_o && !done_o && result_o == '0, "R1",
          "reset outputs", {cs_n_o, sclk_o, sd_oe_o, done_o}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n_o && !sclk_o && !sd_oe_o && !done_o && result_o == '0, "R1",
          "after reset", {cs_n_o, sclk_o, sd_oe_o, done_o}, 4'b1000);
    for (int d = 0; d < 4; d++)
      for (int c = 0; c < 8; c++)
        run_one(d, 3'(c), 12'((c * 'h1A7 + d * 'h35B + 'h5A5) & 'hFFF));
    run_one(0, 3'b111, 12'h000);
    run_one(1, 3'b000, 12'hFFF);
    run_one(0, 3'b101, 12'h800);
    run_one(2, 3'b010, 12'h001);
    finish_run();
  end
endmodule